// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Status

This block receives one asynchronous serial line. It is clocked by the system clock and advances its bit timing only on a single-cycle oversampling tick `tick16`, which arrives sixteen times per bit period. A falling edge on the line starts a frame. The block then checks the start bit at its centre and samples 5 to 8 data bits, least significant first, each at its centre. If parity is enabled, it samples one parity bit after the data. Last, it takes one sample at the centre of the first stop bit. Completed characters are written into a small first-in first-out buffer. The host reads the buffer through a show-ahead port.

Four sticky flags report line problems: break, framing, parity and overrun. Each flag stays set until the host pulses `cmd_err_clear`. A pulse on `cmd_rx_on` arms the receiver. A pulse on `cmd_rx_reset` returns the frame engine to idle, empties the buffer and disarms the receiver.

The frame engine is a state machine with six states:
- `S_IDLE` waits for a low sample on a tick while the receiver is armed (transition to `S_START`).
- `S_START` re-samples the line on the 8th tick. A low sample moves to `S_DATA`. A high sample is noise and returns to `S_IDLE`.
- `S_DATA` samples one bit every 16 ticks. After the last data bit it goes to `S_PARITY` if parity is enabled, or to `S_STOP` if not.
- `S_PARITY` samples the parity bit and moves to `S_STOP`.
- `S_STOP` samples the stop bit. A break moves to `S_BRKWAIT`. Any other outcome returns to `S_IDLE`.
- `S_BRKWAIT` holds until the line samples high on a tick, then returns to `S_IDLE`.

A `cmd_rx_reset` pulse forces `S_IDLE` from any state.

Top module: `uart_rx_err`

## Requirements
- R1: After reset all four error flags are 0, `rd_valid` is 0 and the receiver is disarmed.
- R2: While disarmed, activity on `rxd` stores no character and sets no flag. A `cmd_rx_on` pulse arms the receiver.
- R3: A start bit is accepted only if the line is still low on the 8th tick after the tick that first saw it low. A shorter low pulse is discarded with no character and no flag.
- R4: Data bits are taken least significant first. `cfg_len` selects the character length: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8. The unused upper bits of `rd_data` read 0.
- R5: When `cfg_par_en`=1, one parity bit follows the data. `cfg_par_odd`=1 selects odd parity and 0 selects even parity. A mismatch sets `err_parity`, and the character is still stored.
- R6: The stop check is one sample at the centre of the first stop bit only. A low sample on a character that is not a break sets `err_frame`, and the character is still stored. A new start bit may follow a single stop bit directly.
- R7: A character whose data bits, parity bit (when enabled) and stop sample are all 0 is a break. It sets `err_break` only, stores nothing, and no new frame starts until the line has returned high.
- R8: The buffer holds `DEPTH` characters in arrival order. `rd_data` shows the oldest character while `rd_valid`=1, and `rd_pop` removes it.
- R9: A character that completes while the buffer is full sets `err_overrun` and is discarded. The stored contents are unchanged, and that character sets no other flag.
- R10: Flags are sticky. `cmd_err_clear` clears all four together. A flag being set in the same cycle as a clear stays set.
- R11: `cmd_rx_reset` empties the buffer, idles the frame engine and disarms the receiver. The error flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling tick, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| cmd_rx_on | input | 1 | Pulse: arm the receiver |
| cmd_rx_reset | input | 1 | Pulse: reset receiver, empty buffer, disarm |
| cmd_err_clear | input | 1 | Pulse: clear all error flags |
| cfg_len | input | 2 | Character length code (0..3 = 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_pop | input | 1 | Remove the oldest character |
| rd_valid | output | 1 | Buffer not empty |
| rd_data | output | 8 | Oldest character |
| err_break | output | 1 | Sticky received-break flag |
| err_frame | output | 1 | Sticky framing-error flag |
| err_parity | output | 1 | Sticky parity-error flag |
| err_overrun | output | 1 | Sticky overrun flag |

## Verification
The bench drives a glitch shorter than half a bit. A receiver that skips the mid-start re-check would assemble a spurious 0xFF-like character. Back-to-back frames with a single stop bit catch a design that checks for a second stop bit or needs extra idle time, because such a design would lose the second character. A long low period checks that a break is not also counted as a framing error or stored as a zero character, and that the engine waits for the line to return high. A framing error followed by a short low tail checks that the tail is rejected as noise. An overfilled buffer checks that the fifth character is dropped and not written over the oldest one. The receiver-reset test checks that the sticky flags survive the reset while the buffer is emptied.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP,
        S_BRKWAIT
    } rx_state_e;

    typedef struct packed {
        logic brk;
        logic ferr;
        logic perr;
    } char_err_t;

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              active,
    input  logic              tick,
    input  logic              rxd,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output char_err_t         err
);

    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

    rx_state_e          state, nxt;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   bit_idx;
    logic [IDX_W-1:0]   last_idx;
    logic [DATA_W-1:0]  shreg;
    logic               pbit;
    logic               zero_char;
    logic               perr_c;
    logic               stop_hit;

    assign last_idx  = IDX_W'(4) + IDX_W'(cfg_len);
    assign zero_char = (shreg == '0) && (!cfg_par_en || !pbit);
    assign perr_c    = cfg_par_en && ((^shreg) ^ pbit ^ cfg_par_odd);
    assign stop_hit  = (state == S_STOP) && tick && (cnt == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (active && tick && !rxd) nxt = S_START;
            S_START:   if (tick && cnt == HALF) nxt = rxd ? S_IDLE : S_DATA;
            S_DATA:    if (tick && cnt == LAST && bit_idx == last_idx)
                           nxt = cfg_par_en ? S_PARITY : S_STOP;
            S_PARITY:  if (tick && cnt == LAST) nxt = S_STOP;
            S_STOP:    if (tick && cnt == LAST)
                           nxt = (!rxd && zero_char) ? S_BRKWAIT : S_IDLE;
            S_BRKWAIT: if (tick && rxd) nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
        if (flush) nxt = S_IDLE;
    end

    // bit timing and assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            pbit    <= 1'b0;
        end else if (flush || state == S_IDLE) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            pbit    <= 1'b0;
        end else if (tick) begin
            case (state)
                S_START: cnt <= (cnt == HALF) ? '0 : cnt + 1'b1;
                S_DATA: begin
                    if (cnt == LAST) begin
                        cnt            <= '0;
                        shreg[bit_idx] <= rxd;
                        bit_idx        <= bit_idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_PARITY: begin
                    if (cnt == LAST) begin
                        cnt  <= '0;
                        pbit <= rxd;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_STOP:  cnt <= cnt + 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // registered character outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            data <= '0;
            err  <= '0;
        end else begin
            done <= stop_hit && !flush;
            if (stop_hit) begin
                data     <= shreg;
                err.brk  <= !rxd && zero_char;
                err.ferr <= !rxd && !zero_char;
                err.perr <= perr_c && !(!rxd && zero_char);
            end
        end
    end

    a_r3_noise_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_START && tick && cnt == HALF && rxd && !flush) |=> state == S_IDLE);

    a_r7_break_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BRKWAIT && !rxd && !flush) |=> state == S_BRKWAIT);

    a_r6_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state) == S_STOP);

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);

endmodule

// File: rtl/uart_rx_err.sv
module uart_rx_err
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int OSR   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic       cmd_rx_on,
    input  logic       cmd_rx_reset,
    input  logic       cmd_err_clear,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       rd_pop,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       err_break,
    output logic       err_frame,
    output logic       err_parity,
    output logic       err_overrun
);

    localparam int DATA_W = 8;

    logic [1:0]        rxd_sync;
    logic              rx_armed;
    logic              frm_done;
    logic [DATA_W-1:0] frm_data;
    char_err_t         frm_err;
    logic              fifo_empty, fifo_full;
    logic              is_char, push, ovr_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rxd_sync <= 2'b11;
        else        rxd_sync <= {rxd_sync[0], rxd};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            rx_armed <= 1'b0;
        else if (cmd_rx_reset) rx_armed <= 1'b0;
        else if (cmd_rx_on)    rx_armed <= 1'b1;
    end

    uart_rx_frame #(.OSR(OSR), .DATA_W(DATA_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (cmd_rx_reset),
        .active      (rx_armed),
        .tick        (tick16),
        .rxd         (rxd_sync[1]),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .done        (frm_done),
        .data        (frm_data),
        .err         (frm_err)
    );

    assign is_char = frm_done && !frm_err.brk && !cmd_rx_reset;
    assign push    = is_char && !fifo_full;
    assign ovr_set = is_char && fifo_full;

    uart_rx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (cmd_rx_reset),
        .push  (push),
        .wdata (frm_data),
        .pop   (rd_pop),
        .rdata (rd_data),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    assign rd_valid = !fifo_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_break   <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            if (frm_done && frm_err.brk && !cmd_rx_reset) err_break <= 1'b1;
            else if (cmd_err_clear)                       err_break <= 1'b0;
            if (push && frm_err.ferr)                     err_frame <= 1'b1;
            else if (cmd_err_clear)                       err_frame <= 1'b0;
            if (push && frm_err.perr)                     err_parity <= 1'b1;
            else if (cmd_err_clear)                       err_parity <= 1'b0;
            if (ovr_set)                                  err_overrun <= 1'b1;
            else if (cmd_err_clear)                       err_overrun <= 1'b0;
        end
    end

    a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && !frm_err.brk && fifo_full && !cmd_rx_reset) |=> err_overrun);

    a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_err_clear && !frm_done) |=> !(err_break || err_frame || err_parity || err_overrun));

    a_r11_reset_empties: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rx_reset |=> !rd_valid);

    a_r2_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_armed && !$past(rx_armed) && !frm_done) |=> $stable(rd_valid) || !rd_valid);

endmodule

// File: tb/tb_uart_rx_err.sv
module tb_uart_rx_err;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       cmd_rx_on = 1'b0, cmd_rx_reset = 1'b0, cmd_err_clear = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       rd_pop = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       err_break, err_frame, err_parity, err_overrun;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;
    logic [1:0] tdiv = 2'd0;

    uart_rx_err dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cmd_rx_on(cmd_rx_on), .cmd_rx_reset(cmd_rx_reset), .cmd_err_clear(cmd_err_clear),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rd_pop(rd_pop), .rd_valid(rd_valid), .rd_data(rd_data),
        .err_break(err_break), .err_frame(err_frame), .err_parity(err_parity),
        .err_overrun(err_overrun)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        tdiv   <= tdiv + 2'd1;
        tick16 <= (tdiv == 2'd3);
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic ticks(input int n);
        repeat (4 * n) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    function automatic logic [3:0] flags();
        return {err_break, err_frame, err_parity, err_overrun};
    endfunction

    // one frame: start, nbits data LSB first, optional parity, one stop of given level
    task automatic frame(input logic [7:0] d, input int nbits, input bit par,
                         input logic pb, input logic stop, input int stop_ticks);
        rxd = 1'b0; ticks(16);
        for (int i = 0; i < nbits; i++) begin
            rxd = d[i]; ticks(16);
        end
        if (par) begin
            rxd = pb; ticks(16);
        end
        rxd = stop; ticks(stop_ticks);
        rxd = 1'b1;
    endtask

    task automatic pop_one();
        @(negedge clk); rd_pop = 1'b1;
        @(negedge clk); rd_pop = 1'b0;
    endtask

    task automatic t_reset();
        chk(flags(), 4'b0, "R1 flags after reset");
        chk(rd_valid, 1'b0, "R1 buffer empty after reset");
    endtask

    task automatic t_disarmed();
        frame(8'h3C, 8, 0, 1'b0, 1'b1, 16); ticks(20);
        chk(rd_valid, 1'b0, "R2 disarmed stores nothing");
        chk(flags(), 4'b0, "R2 disarmed sets no flag");
        pulse(cmd_rx_on);
    endtask

    task automatic t_basic8();
        cfg_len = 2'd3; cfg_par_en = 1'b0;
        frame(8'hA5, 8, 0, 1'b0, 1'b1, 16); ticks(20);
        chk(rd_valid, 1'b1, "R4 char stored");
        chk(rd_data, 8'hA5, "R4 8-bit data");
        chk(flags(), 4'b0, "R4 no flags");
        pop_one();
        chk(rd_valid, 1'b0, "R8 pop empties");
    endtask

    task automatic t_parity();
        logic [7:0] d5, d7;
        d5 = 8'h15;
        cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        frame(8'hF5, 5, 1, ^d5, 1'b1, 16); ticks(20);
        chk(rd_data, 8'h15, "R4 5-bit data upper zero");
        chk(err_parity, 1'b0, "R5 even parity good");
        pop_one();
        d7 = 8'h4B;
        cfg_len = 2'd2; cfg_par_odd = 1'b1;
        frame(d7, 7, 1, (^d7) ^ 1'b1, 1'b1, 16); ticks(20);
        chk(rd_data, 8'h4B, "R4 7-bit data");
        chk(err_parity, 1'b0, "R5 odd parity good");
        pop_one();
        frame(d7, 7, 1, ^d7, 1'b1, 16); ticks(20);
        chk(err_parity, 1'b1, "R5 parity mismatch flagged");
        chk(rd_data, 8'h4B, "R5 bad-parity char stored");
        pop_one();
        pulse(cmd_err_clear);
        chk(flags(), 4'b0, "R10 clear all");
        cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    endtask

    task automatic t_frame_err();
        frame(8'h81, 8, 0, 1'b0, 1'b0, 12); ticks(40);
        chk(err_frame, 1'b1, "R6 low stop flagged");
        chk(err_break, 1'b0, "R6 not a break");
        chk(rd_data, 8'h81, "R6 char stored");
        pop_one();
        chk(rd_valid, 1'b0, "R3 short low tail dropped");
        pulse(cmd_err_clear);
    endtask

    task automatic t_back_to_back();
        frame(8'h11, 8, 0, 1'b0, 1'b1, 16);
        frame(8'h22, 8, 0, 1'b0, 1'b1, 16); ticks(20);
        chk(rd_data, 8'h11, "R6 first back-to-back char");
        pop_one();
        chk(rd_data, 8'h22, "R6 second back-to-back char");
        pop_one();
        chk(flags(), 4'b0, "R6 single stop no error");
    endtask

    task automatic t_noise();
        rxd = 1'b0; ticks(3); rxd = 1'b1; ticks(200);
        chk(rd_valid, 1'b0, "R3 glitch rejected");
        chk(flags(), 4'b0, "R3 glitch no flag");
    endtask

    task automatic t_break();
        rxd = 1'b0; ticks(16 * 14);
        chk(err_break, 1'b1, "R7 break flagged");
        chk(rd_valid, 1'b0, "R7 break stores nothing");
        rxd = 1'b1; ticks(24);
        chk(rd_valid, 1'b0, "R7 no char after break");
        chk(flags(), 4'b1000, "R7 only break flag");
        pulse(cmd_err_clear);
        frame(8'h5A, 8, 0, 1'b0, 1'b1, 16); ticks(20);
        chk(rd_data, 8'h5A, "R7 receive resumes after mark");
        pop_one();
    endtask

    task automatic t_overrun();
        for (int i = 0; i < 5; i++) frame(8'h30 + 8'(i), 8, 0, 1'b0, 1'b1, 16);
        ticks(20);
        chk(err_overrun, 1'b1, "R9 overrun flagged");
        chk({err_break, err_frame, err_parity}, 3'b0, "R9 no other flag");
        for (int i = 0; i < 4; i++) begin
            chk(rd_data, 8'h30 + 8'(i), "R8 order kept under overrun");
            pop_one();
        end
        chk(rd_valid, 1'b0, "R9 fifth char discarded");
    endtask

    task automatic t_rx_reset();
        frame(8'h77, 8, 0, 1'b0, 1'b1, 16); ticks(20);
        pulse(cmd_rx_reset);
        chk(rd_valid, 1'b0, "R11 buffer emptied");
        chk(err_overrun, 1'b1, "R11 flags kept");
        frame(8'h66, 8, 0, 1'b0, 1'b1, 16); ticks(20);
        chk(rd_valid, 1'b0, "R11 disarmed after reset");
        pulse(cmd_err_clear);
        chk(flags(), 4'b0, "R10 clear after reset");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_disarmed();
        t_basic8();
        t_parity();
        t_frame_err();
        t_back_to_back();
        t_noise();
        t_break();
        t_overrun();
        t_rx_reset();
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule